// File: doc/BRIEF.md
# Physical Memory Protection Checker

The block keeps a small table of protection entries. Each entry has an 8-bit configuration byte and an address register that counts 4-byte words. Every memory access presents a word address, an access type (read, write or execute) and a privilege level. In the same cycle the block answers with a fault flag. Matching can use a top-of-range bound set by the entry below, a single naturally aligned word, or a naturally aligned power-of-two region. When several entries match, the lowest-numbered one decides the result.

Software reaches the table through a CSR-style port. The port has a one-cycle write strobe and a combinational readback path. Locked entries turn away writes until the asynchronous reset. While no entry is locked, machine-mode accesses are never faulted. A locked entry also binds machine mode to its own permission bits.

Top module: `pmp_guard`

## Requirements
- R1: Configuration byte layout: bit 0 read, bit 1 write, bit 2 execute, bits 4:3 match mode (0 off, 1 top-of-range, 2 single word, 3 power-of-two region), bit 7 lock. Bits 6:5 read back as zero. After an entry's lock bit is set, writes to that entry's byte and to its address register are ignored.
- R2: While entry i+1 is locked in top-of-range mode, writes to the address register of entry i are ignored. Writes to the configuration byte of entry i still take effect.
- R3: Asserting rst_ni low clears every configuration byte, lock bits included, and every address register to zero. After reset, writes take effect again.
- R4: While no entry is locked, a machine-mode access (privilege 3) never faults.
- R5: A machine-mode access that matches no enabled entry never faults.
- R6: A machine-mode access whose deciding entry is unlocked never faults, whatever that entry's permission bits are.
- R7: A machine-mode access whose deciding entry is locked passes only when that entry grants the requested type. The type encoding is 0 read, 1 write, 2 execute.
- R8: An access below machine mode is decided by the matching entry's permission bits, whether or not the entry is locked.
- R9: An access below machine mode that matches no entry faults exactly when at least one entry's mode is not off.
- R10: When several entries match, only the lowest-numbered matching entry decides the result.
- R11: A top-of-range entry i matches words w with addr[i-1] <= w < addr[i]. For entry 0 the lower bound is 0.
- R12: A single-word entry matches only the word equal to its address register.
- R13: A power-of-two entry whose address register ends in k one bits matches the 2^(k+1) words that share the register's upper bits.
- R14: The fault result and the readback data are combinational from the current inputs and table state. A CSR write becomes visible from the clock edge that samples it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset; clears the table and all locks |
| csr_we_i | input | 1 | Write strobe for the table port |
| csr_cfg_sel_i | input | 1 | 1 selects the configuration byte, 0 selects the address register |
| csr_idx_i | input | 3 | Entry index for writes |
| csr_wdata_i | input | 32 | Write data; bits 7:0 are used for configuration writes |
| rd_cfg_sel_i | input | 1 | 1 reads the configuration byte, 0 reads the address register |
| rd_idx_i | input | 3 | Entry index for readback |
| rd_data_o | output | 32 | Readback data; configuration bytes are zero-extended |
| acc_word_i | input | 32 | Access address in 4-byte units |
| acc_type_i | input | 2 | 0 read, 1 write, 2 execute |
| acc_priv_i | input | 2 | Privilege level; 3 is machine mode |
| acc_fault_o | output | 1 | 1 when the access is refused |

## Verification
Assertions check two kinds of rule on every clock. The first is the lock rules: a locked entry, and the register below a locked top-of-range entry, stay stable. The second is the machine-mode exemptions: no fault when nothing is locked, when nothing matches, or when the deciding entry is unlocked. The bench scenarios cover what a single-cycle property cannot show. These are the exact range edges for each match mode, the priority between overlapping entries, and permission decisions below machine mode. They also cover the way a reset clears the locks and lets writes through again, all compared against hand-computed expectations.

// File: rtl/pmp_guard_pkg.sv
package pmp_guard_pkg;

  typedef enum logic [1:0] {
    AM_OFF   = 2'd0,
    AM_TOR   = 2'd1,
    AM_NA4   = 2'd2,
    AM_NAPOT = 2'd3
  } amode_e;

  typedef enum logic [1:0] {
    ACC_READ  = 2'd0,
    ACC_WRITE = 2'd1,
    ACC_EXEC  = 2'd2
  } acc_e;

  localparam logic [1:0] PRIV_M = 2'd3;

  // stored form of the configuration byte; reserved bits are not kept
  typedef struct packed {
    logic   lock;
    amode_e amode;
    logic   x;
    logic   w;
    logic   r;
  } cfg_t;

  function automatic cfg_t cfg_from_byte(logic [7:0] b);
    cfg_t c;
    c.lock  = b[7];
    c.amode = amode_e'(b[4:3]);
    c.x     = b[2];
    c.w     = b[1];
    c.r     = b[0];
    return c;
  endfunction

  function automatic logic [7:0] cfg_to_byte(cfg_t c);
    return {c.lock, 2'b00, c.amode, c.x, c.w, c.r};
  endfunction

endpackage

// File: rtl/pmp_entry_regs.sv
module pmp_entry_regs
  import pmp_guard_pkg::*;
#(
  parameter int unsigned N_ENTRIES = 8,
  parameter int unsigned AW        = 32,
  localparam int unsigned IDX_W    = $clog2(N_ENTRIES)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic             cfg_sel_i,
  input  logic [IDX_W-1:0] idx_i,
  input  logic [AW-1:0]    wdata_i,
  output cfg_t             cfg_o  [N_ENTRIES],
  output logic [AW-1:0]    addr_o [N_ENTRIES]
);

  cfg_t          cfg_q  [N_ENTRIES];
  logic [AW-1:0] addr_q [N_ENTRIES];

  for (genvar i = 0; i < N_ENTRIES; i++) begin : g_ent
    logic sel;
    logic frozen_by_above;
    logic cfg_wr;
    logic addr_wr;

    assign sel = we_i && (idx_i == IDX_W'(i));

    if (i < N_ENTRIES - 1) begin : g_above
      assign frozen_by_above = cfg_q[i+1].lock && (cfg_q[i+1].amode == AM_TOR);
    end else begin : g_top
      assign frozen_by_above = 1'b0;
    end

    assign cfg_wr  = sel && cfg_sel_i && !cfg_q[i].lock;
    assign addr_wr = sel && !cfg_sel_i && !cfg_q[i].lock && !frozen_by_above;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        cfg_q[i]  <= '0;
        addr_q[i] <= '0;
      end else begin
        if (cfg_wr)  cfg_q[i]  <= cfg_from_byte(wdata_i[7:0]);
        if (addr_wr) addr_q[i] <= wdata_i;
      end
    end

    assign cfg_o[i]  = cfg_q[i];
    assign addr_o[i] = addr_q[i];

    assert_locked_cfg_stable_R1 : assert property (@(posedge clk_i) disable iff (!rst_ni)
      cfg_q[i].lock |=> $stable(cfg_q[i]));

    assert_locked_addr_stable_R1 : assert property (@(posedge clk_i) disable iff (!rst_ni)
      cfg_q[i].lock |=> $stable(addr_q[i]));

    if (i < N_ENTRIES - 1) begin : g_chk_below
      assert_tor_freezes_below_R2 : assert property (@(posedge clk_i) disable iff (!rst_ni)
        (cfg_q[i+1].lock && cfg_q[i+1].amode == AM_TOR) |=> $stable(addr_q[i]));
    end
  end

endmodule

// File: rtl/pmp_match.sv
module pmp_match
  import pmp_guard_pkg::*;
#(
  parameter int unsigned N_ENTRIES = 8,
  parameter int unsigned AW        = 32
) (
  input  cfg_t                 cfg_i  [N_ENTRIES],
  input  logic [AW-1:0]        addr_i [N_ENTRIES],
  input  logic [AW-1:0]        word_i,
  output logic [N_ENTRIES-1:0] hit_o
);

  for (genvar i = 0; i < N_ENTRIES; i++) begin : g_m
    logic [AW-1:0] lo;
    logic [AW-1:0] napot_mask;

    if (i == 0) begin : g_lo0
      assign lo = '0;
    end else begin : g_lon
      assign lo = addr_i[i-1];
    end

    // trailing ones plus the first zero mark the don't-care bits
    assign napot_mask = addr_i[i] ^ (addr_i[i] + AW'(1));

    always_comb begin
      unique case (cfg_i[i].amode)
        AM_TOR:   hit_o[i] = (word_i >= lo) && (word_i < addr_i[i]);
        AM_NA4:   hit_o[i] = (word_i == addr_i[i]);
        AM_NAPOT: hit_o[i] = ((word_i | napot_mask) == (addr_i[i] | napot_mask));
        default:  hit_o[i] = 1'b0;
      endcase
    end
  end

endmodule

// File: rtl/pmp_decide.sv
module pmp_decide
  import pmp_guard_pkg::*;
#(
  parameter int unsigned N_ENTRIES = 8
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  cfg_t                 cfg_i [N_ENTRIES],
  input  logic [N_ENTRIES-1:0] hit_i,
  input  logic [1:0]           priv_i,
  input  logic [1:0]           type_i,
  output logic                 fault_o
);

  logic found;
  cfg_t sel_cfg;
  logic any_en;
  logic any_lock;
  logic perm;
  logic is_m;

  assign is_m = (priv_i == PRIV_M);

  // lowest index wins: scan downward so the last assignment is the smallest
  always_comb begin
    found   = 1'b0;
    sel_cfg = '0;
    for (int i = N_ENTRIES - 1; i >= 0; i--) begin
      if (hit_i[i]) begin
        found   = 1'b1;
        sel_cfg = cfg_i[i];
      end
    end
  end

  always_comb begin
    any_en   = 1'b0;
    any_lock = 1'b0;
    for (int i = 0; i < N_ENTRIES; i++) begin
      any_en   = any_en   | (cfg_i[i].amode != AM_OFF);
      any_lock = any_lock | cfg_i[i].lock;
    end
  end

  always_comb begin
    unique case (type_i)
      ACC_READ:  perm = sel_cfg.r;
      ACC_WRITE: perm = sel_cfg.w;
      ACC_EXEC:  perm = sel_cfg.x;
      default:   perm = 1'b0;
    endcase
  end

  always_comb begin
    if (!found)                    fault_o = !is_m && any_en;
    else if (is_m && !sel_cfg.lock) fault_o = 1'b0;
    else                           fault_o = !perm;
  end

  assert_m_free_without_locks_R4 : assert property (@(posedge clk_i) disable iff (!rst_ni)
    (is_m && !any_lock) |-> !fault_o);

  assert_m_nomatch_pass_R5 : assert property (@(posedge clk_i) disable iff (!rst_ni)
    (is_m && hit_i == '0) |-> !fault_o);

  assert_m_unlocked_pass_R6 : assert property (@(posedge clk_i) disable iff (!rst_ni)
    (is_m && found && !sel_cfg.lock) |-> !fault_o);

  assert_idle_table_pass_R9 : assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!any_en) |-> !fault_o);

endmodule

// File: rtl/pmp_guard.sv
module pmp_guard
  import pmp_guard_pkg::*;
#(
  parameter int unsigned N_ENTRIES = 8,
  parameter int unsigned PA_W      = 34,
  localparam int unsigned AW       = PA_W - 2,
  localparam int unsigned IDX_W    = $clog2(N_ENTRIES)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             csr_we_i,
  input  logic             csr_cfg_sel_i,
  input  logic [IDX_W-1:0] csr_idx_i,
  input  logic [AW-1:0]    csr_wdata_i,
  input  logic             rd_cfg_sel_i,
  input  logic [IDX_W-1:0] rd_idx_i,
  output logic [AW-1:0]    rd_data_o,
  input  logic [AW-1:0]    acc_word_i,
  input  logic [1:0]       acc_type_i,
  input  logic [1:0]       acc_priv_i,
  output logic             acc_fault_o
);

  cfg_t                 cfg  [N_ENTRIES];
  logic [AW-1:0]        addr [N_ENTRIES];
  logic [N_ENTRIES-1:0] hit;

  pmp_entry_regs #(.N_ENTRIES(N_ENTRIES), .AW(AW)) u_regs (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .we_i      (csr_we_i),
    .cfg_sel_i (csr_cfg_sel_i),
    .idx_i     (csr_idx_i),
    .wdata_i   (csr_wdata_i),
    .cfg_o     (cfg),
    .addr_o    (addr)
  );

  pmp_match #(.N_ENTRIES(N_ENTRIES), .AW(AW)) u_match (
    .cfg_i  (cfg),
    .addr_i (addr),
    .word_i (acc_word_i),
    .hit_o  (hit)
  );

  pmp_decide #(.N_ENTRIES(N_ENTRIES)) u_decide (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .cfg_i   (cfg),
    .hit_i   (hit),
    .priv_i  (acc_priv_i),
    .type_i  (acc_type_i),
    .fault_o (acc_fault_o)
  );

  assign rd_data_o = rd_cfg_sel_i ? AW'(cfg_to_byte(cfg[rd_idx_i])) : addr[rd_idx_i];

  assert_rsvd_zero_R1 : assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_cfg_sel_i |-> (rd_data_o[6:5] == 2'b00 && rd_data_o[AW-1:8] == '0));

endmodule

// File: tb/pmp_guard_tb_top.sv
`timescale 1ns/100ps
module pmp_guard_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        csr_we = 1'b0;
  logic        csr_cfg_sel = 1'b0;
  logic [2:0]  csr_idx = '0;
  logic [31:0] csr_wdata = '0;
  logic        rd_cfg_sel = 1'b0;
  logic [2:0]  rd_idx = '0;
  logic [31:0] rd_data;
  logic [31:0] acc_word = '0;
  logic [1:0]  acc_type = '0;
  logic [1:0]  acc_priv = '0;
  logic        acc_fault;

  always #2.5 clk = ~clk;

  pmp_guard dut_i (
    .clk_i         (clk),
    .rst_ni        (rst_n),
    .csr_we_i      (csr_we),
    .csr_cfg_sel_i (csr_cfg_sel),
    .csr_idx_i     (csr_idx),
    .csr_wdata_i   (csr_wdata),
    .rd_cfg_sel_i  (rd_cfg_sel),
    .rd_idx_i      (rd_idx),
    .rd_data_o     (rd_data),
    .acc_word_i    (acc_word),
    .acc_type_i    (acc_type),
    .acc_priv_i    (acc_priv),
    .acc_fault_o   (acc_fault)
  );

  typedef struct {
    bit          is_rd;
    logic [31:0] exp;
    string       tag;
  } item_t;

  item_t sb_q[$];
  int    checks = 0;
  int    errors = 0;
  bit    done = 0;

  localparam logic [1:0] RD = 2'd0, WR = 2'd1, EX = 2'd2;
  localparam logic [1:0] PU = 2'd0, PM = 2'd3;

  // monitor: compares between edges
  initial begin
    forever begin
      @(negedge clk);
      while (sb_q.size() > 0) begin
        item_t it;
        logic [31:0] act;
        it  = sb_q.pop_front();
        act = it.is_rd ? rd_data : {31'b0, acc_fault};
        checks++;
        if (act !== it.exp) begin
          errors++;
          $display("FAIL %s: actual 0x%0h expected 0x%0h", it.tag, act, it.exp);
        end
      end
    end
  end

  task automatic csr_wr(bit cfg, int idx, logic [31:0] d);
    @(posedge clk); #1;
    csr_we = 1'b1; csr_cfg_sel = cfg; csr_idx = 3'(idx); csr_wdata = d;
    @(posedge clk); #1;
    csr_we = 1'b0;
  endtask

  task automatic chk_rd(bit cfg, int idx, logic [31:0] exp, string tag);
    item_t it;
    @(posedge clk); #1;
    rd_cfg_sel = cfg; rd_idx = 3'(idx);
    it.is_rd = 1'b1; it.exp = exp; it.tag = tag;
    sb_q.push_back(it);
  endtask

  task automatic chk_acc(logic [31:0] w, logic [1:0] ty, logic [1:0] pv, bit exp, string tag);
    item_t it;
    @(posedge clk); #1;
    acc_word = w; acc_type = ty; acc_priv = pv;
    it.is_rd = 1'b0; it.exp = {31'b0, exp}; it.tag = tag;
    sb_q.push_back(it);
  endtask

  task automatic pulse_reset();
    @(posedge clk); #1;
    rst_n = 1'b0;
    @(posedge clk); #1;
    rst_n = 1'b1;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // reset state
    chk_rd(1, 0, 32'h0, "R3 cfg0 after reset");
    chk_rd(0, 0, 32'h0, "R3 addr0 after reset");
    chk_acc(32'h123, RD, PU, 0, "R9 no enabled entry, user pass");

    // table: e0 TOR [0,0x100) R; e1 NA4 0x200 W; e2 NAPOT 0x400..0x40F X; e3 NAPOT 0x200..0x2FF RWX
    csr_wr(0, 0, 32'h100); csr_wr(1, 0, 32'h09);
    csr_wr(0, 1, 32'h200); csr_wr(1, 1, 32'h12);
    csr_wr(0, 2, 32'h407); csr_wr(1, 2, 32'h1C);
    csr_wr(0, 3, 32'h27F); csr_wr(1, 3, 32'h1F);
    chk_rd(1, 1, 32'h12, "R14 cfg1 written");
    csr_wr(1, 7, 32'hFF);   // reserved bits dropped, then lock entry 7 NAPOT addr 0 -> words 0..1
    chk_rd(1, 7, 32'h9F, "R1 reserved bits read zero");
    pulse_reset();
    chk_rd(1, 7, 32'h00, "R3 lock cleared by reset");
    csr_wr(0, 0, 32'h100); csr_wr(1, 0, 32'h09);
    csr_wr(0, 1, 32'h200); csr_wr(1, 1, 32'h12);
    csr_wr(0, 2, 32'h407); csr_wr(1, 2, 32'h1C);
    csr_wr(0, 3, 32'h27F); csr_wr(1, 3, 32'h1F);

    chk_acc(32'h50,  RD, PU, 0, "R11 TOR inside, read granted");
    chk_acc(32'h0,   RD, PU, 0, "R11 TOR entry0 lower bound 0");
    chk_acc(32'h50,  WR, PU, 1, "R8 TOR write not granted");
    chk_acc(32'hFF,  RD, PU, 0, "R11 TOR last word");
    chk_acc(32'h100, RD, PU, 1, "R11 TOR upper bound exclusive");
    chk_acc(32'h200, WR, PU, 0, "R12 NA4 write granted");
    chk_acc(32'h200, RD, PU, 1, "R10 entry1 decides over entry3");
    chk_acc(32'h201, RD, PU, 0, "R12 NA4 single word, entry3 takes next");
    chk_acc(32'h2FF, EX, PU, 0, "R13 NAPOT k=7 top word");
    chk_acc(32'h300, EX, PU, 1, "R13 NAPOT k=7 past end");
    chk_acc(32'h40F, EX, PU, 0, "R13 NAPOT k=3 top word");
    chk_acc(32'h400, RD, PU, 1, "R13 NAPOT execute only");
    chk_acc(32'h410, EX, PU, 1, "R9 no match with enabled entries");
    chk_acc(32'h50,  WR, PM, 0, "R4 machine, no locks");
    chk_acc(32'h410, EX, PM, 0, "R4 machine, no locks, no match");

    // e4 bound 0x800 (off), e5 TOR [0x800,0x880) locked R; lock e0
    csr_wr(0, 4, 32'h800);
    csr_wr(0, 5, 32'h880); csr_wr(1, 5, 32'h89);
    csr_wr(1, 0, 32'h89);
    csr_wr(0, 4, 32'h123);
    chk_rd(0, 4, 32'h800, "R2 addr below locked TOR frozen");
    csr_wr(1, 4, 32'h01);
    chk_rd(1, 4, 32'h01, "R2 cfg below locked TOR writable");
    csr_wr(1, 0, 32'h0F);
    chk_rd(1, 0, 32'h89, "R1 locked cfg write ignored");
    csr_wr(0, 0, 32'h55);
    chk_rd(0, 0, 32'h100, "R1 locked addr write ignored");

    chk_acc(32'h50,  WR, PM, 1, "R7 machine locked, write refused");
    chk_acc(32'h50,  RD, PM, 0, "R7 machine locked, read granted");
    chk_acc(32'h840, EX, PM, 1, "R7 machine locked TOR, exec refused");
    chk_acc(32'h840, RD, PM, 0, "R7 machine locked TOR, read granted");
    chk_acc(32'h200, RD, PM, 0, "R6 machine unlocked entry, no R bit");
    chk_acc(32'h400, WR, PM, 0, "R6 machine unlocked NAPOT");
    chk_acc(32'h900, RD, PM, 0, "R5 machine no match with locks");
    chk_acc(32'h840, RD, PU, 0, "R8 user locked entry read");
    chk_acc(32'h87F, WR, PU, 1, "R8 user locked entry write");
    chk_acc(32'h880, RD, PU, 1, "R11 TOR entry5 upper bound exclusive");
    chk_acc(32'h900, EX, PU, 1, "R9 user no match faults");

    pulse_reset();
    chk_rd(1, 0, 32'h00, "R3 cfg0 cleared");
    chk_rd(0, 4, 32'h00, "R3 addr4 cleared");
    chk_acc(32'h50, WR, PU, 0, "R3 table empty after reset");
    csr_wr(0, 4, 32'h321);
    chk_rd(0, 4, 32'h321, "R3 write accepted after reset");
    csr_wr(1, 0, 32'h1F);
    chk_rd(1, 0, 32'h1F, "R3 cfg0 write accepted after reset");

    @(posedge clk);
    @(negedge clk);
    #1;
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule